// File: doc/BRIEF.md
# Serial NOR Flash Page Program-and-Verify Sequencer

This controller programs one page of a serial NOR flash and proves the write took. A single start pulse runs a fixed sequence of four kinds of command frames on a byte-level SPI transaction interface: a write-enable frame, a page-program frame that carries the page contents from a local page buffer, repeated status frames until the device reports idle, and a read-back frame whose returned bytes are compared against the buffer.

Chip select is held low for the whole of every frame and released for at least one clock between frames, so the flash never sees a frame split in two. The result is a one-clock `done` pulse together with sticky flags. On a data mismatch the flags give the first failing offset and the expected and received bytes. If the device stays busy past a caller-supplied number of status reads, the flags report a timeout instead.

The page buffer is loaded through a simple write port before start. Each byte transfer is a request/acknowledge pair: the controller holds `xfer_req` high with `xfer_tx` stable, and the shifter pulses `xfer_ack` for one clock with the received byte on `xfer_rx`.

Top module: `spi_page_verify`

## Requirements
- R1: After reset `cs_n`=1, `xfer_req`=0, `busy`=0, `done`=0, `mismatch`=0 and `timeout_err`=0.
- R2: A start accepted while idle first sends the single byte 0x06 as a frame of its own.
- R3: The next frame is 0x02, then `page_addr` bits [23:16], [15:8] and [7:0] as latched at start, then buffer bytes at offsets 0 to PAGE_BYTES-1 in ascending order.
- R4: Each status frame sends 0x05 then 0x00. The byte received for the second is the status. If its bit 0 is 1 (busy), another status frame follows; all other bits are ignored.
- R5: Once a status reads bit 0 = 0, a read frame follows: 0x03, the same three address bytes, then PAGE_BYTES bytes of 0x00.
- R6: `cs_n` is low for an entire frame and rises only after the acknowledge of the frame's last byte. It is high for at least one clock between frames and whenever the block is idle. `xfer_req` is high only while `cs_n` is low.
- R7: While `xfer_req` is high and no acknowledge has arrived, `xfer_req` stays high and `xfer_tx` does not change.
- R8: When every read byte equals the buffer byte at the same offset, the sequence ends with `done` pulsed and `mismatch`=0.
- R9: On any difference, `mismatch`=1, and `fail_offset`, `fail_expected` and `fail_actual` hold the lowest failing offset and its bytes. Later differences do not overwrite them, and the read frame still runs to its full length.
- R10: After `poll_limit` status reads in a row that report busy (a limit of 0 acts as 1), `timeout_err`=1 and `done` pulses with no read frame sent. `timeout_err` and `mismatch` are never both 1.
- R11: `done` is high for exactly one clock. The result flags hold until the next accepted start, which clears them.
- R12: `start` while `busy`=1 is ignored: no frames beyond the running sequence are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| page_addr | input | 24 | Flash byte address of the page, latched at start |
| poll_limit | input | TO_W | Maximum busy status reads before timeout |
| buf_wr_en | input | 1 | Page buffer write strobe |
| buf_wr_addr | input | OFF_W | Page buffer write offset |
| buf_wr_data | input | 8 | Page buffer write byte |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_req | output | 1 | Byte transfer request |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Byte transfer complete, one clock |
| xfer_rx | input | 8 | Byte received, valid with xfer_ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| mismatch | output | 1 | Read-back differed from buffer |
| timeout_err | output | 1 | Busy polling exceeded limit |
| fail_offset | output | OFF_W | First failing byte offset |
| fail_expected | output | 8 | Buffer byte at that offset |
| fail_actual | output | 8 | Received byte at that offset |

## Verification
The bench builds the block with PAGE_BYTES=16 and TO_W=8. The short page lets each run hit the first and the last data offset of both program and read frames within a few hundred clocks. The narrow limit lets small `poll_limit` values, including 0, drive the block into timeout. The bench also varies the acknowledge latency from zero to two clocks, so the request-hold rule is exercised between fast and slow bytes.

// File: rtl/spi_pv_pkg.sv
package spi_pv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_DONE
    } st_e;

    typedef enum logic [1:0] {
        PH_WREN,
        PH_PROG,
        PH_POLL,
        PH_READ
    } ph_e;

    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_PAGE_PROG = 8'h02;
    localparam logic [7:0] OP_STATUS_RD = 8'h05;
    localparam logic [7:0] OP_DATA_RD   = 8'h03;
    localparam logic [7:0] FILL_BYTE    = 8'h00;

    localparam int HDR_BYTES  = 4;
    localparam int ADDR_BYTES = 3;

endpackage

// File: rtl/spi_pv_buf.sv
module spi_pv_buf #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spi_pv_txgen.sv
module spi_pv_txgen
    import spi_pv_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  ph_e              phase,
    input  logic [IDX_W-1:0] idx,
    input  logic [23:0]      addr,
    input  logic [7:0]       buf_byte,
    output logic [7:0]       tx
);

    logic [7:0] addr_byte [ADDR_BYTES];

    // Address bytes go out most significant first.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
        assign addr_byte[g] = addr[(ADDR_BYTES-1-g)*8 +: 8];
    end

    always_comb begin
        tx = FILL_BYTE;
        unique case (phase)
            PH_WREN: tx = OP_WR_ENABLE;
            PH_POLL: tx = (idx == '0) ? OP_STATUS_RD : FILL_BYTE;
            PH_PROG, PH_READ: begin
                if (idx == '0) begin
                    tx = (phase == PH_PROG) ? OP_PAGE_PROG : OP_DATA_RD;
                end else if (idx == IDX_W'(1)) begin
                    tx = addr_byte[0];
                end else if (idx == IDX_W'(2)) begin
                    tx = addr_byte[1];
                end else if (idx == IDX_W'(3)) begin
                    tx = addr_byte[2];
                end else begin
                    tx = (phase == PH_PROG) ? buf_byte : FILL_BYTE;
                end
            end
            default: tx = FILL_BYTE;
        endcase
    end

endmodule

// File: rtl/spi_pv_poll_timer.sv
module spi_pv_poll_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            inc,
    input  logic [TO_W-1:0] limit,
    output logic            last_allowed
);

    logic [TO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + TO_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // The busy read now being counted is the last one allowed.
    assign last_allowed = ({1'b0, cnt_q} + (TO_W+1)'(1)) >= {1'b0, limit};

endmodule

// File: rtl/spi_pv_compare.sv
module spi_pv_compare #(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       exp_byte,
    input  logic [7:0]       act_byte,
    output logic             mismatch,
    output logic [OFF_W-1:0] fail_off,
    output logic [7:0]       fail_exp,
    output logic [7:0]       fail_act
);

    typedef struct packed {
        logic             mm;
        logic [OFF_W-1:0] off;
        logic [7:0]       exp_b;
        logic [7:0]       act_b;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d = cmp_q;
        if (clr) begin
            cmp_d = '0;
        end else if (en && (act_byte != exp_byte) && !cmp_q.mm) begin
            cmp_d.mm    = 1'b1;
            cmp_d.off   = off;
            cmp_d.exp_b = exp_byte;
            cmp_d.act_b = act_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign mismatch = cmp_q.mm;
    assign fail_off = cmp_q.off;
    assign fail_exp = cmp_q.exp_b;
    assign fail_act = cmp_q.act_b;

endmodule

// File: rtl/spi_page_verify.sv
module spi_page_verify
    import spi_pv_pkg::*;
#(
    parameter int  PAGE_BYTES = 256,
    parameter int  TO_W       = 16,
    localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [23:0]      page_addr,
    input  logic [TO_W-1:0]  poll_limit,
    input  logic             buf_wr_en,
    input  logic [OFF_W-1:0] buf_wr_addr,
    input  logic [7:0]       buf_wr_data,
    output logic             cs_n,
    output logic             xfer_req,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_ack,
    input  logic [7:0]       xfer_rx,
    output logic             busy,
    output logic             done,
    output logic             mismatch,
    output logic             timeout_err,
    output logic [OFF_W-1:0] fail_offset,
    output logic [7:0]       fail_expected,
    output logic [7:0]       fail_actual
);

    localparam int IDX_W = $clog2(PAGE_BYTES + HDR_BYTES + 1);
    localparam logic [IDX_W-1:0] DATA_FIRST = IDX_W'(HDR_BYTES);
    localparam logic [IDX_W-1:0] PAGE_LAST  = IDX_W'(PAGE_BYTES + HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] POLL_LAST  = IDX_W'(1);

    typedef struct packed {
        st_e              st;
        ph_e              ph;
        ph_e              nxt_ph;
        logic [IDX_W-1:0] idx;
        logic [23:0]      addr;
        logic             tmo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_clr, tmr_inc, tmr_last;
    logic             cmp_clr, cmp_en;
    logic [7:0]       buf_byte;
    logic [OFF_W-1:0] data_off;
    logic [IDX_W-1:0] last_idx;

    assign data_off = OFF_W'(ctl_q.idx - DATA_FIRST);

    spi_pv_buf #(.DEPTH(PAGE_BYTES)) u_buf (
        .clk     (clk),
        .wr_en   (buf_wr_en),
        .wr_addr (buf_wr_addr),
        .wr_data (buf_wr_data),
        .rd_addr (data_off),
        .rd_data (buf_byte)
    );

    spi_pv_txgen #(.IDX_W(IDX_W)) u_txgen (
        .phase    (ctl_q.ph),
        .idx      (ctl_q.idx),
        .addr     (ctl_q.addr),
        .buf_byte (buf_byte),
        .tx       (xfer_tx)
    );

    spi_pv_poll_timer #(.TO_W(TO_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (tmr_clr),
        .inc          (tmr_inc),
        .limit        (poll_limit),
        .last_allowed (tmr_last)
    );

    spi_pv_compare #(.OFF_W(OFF_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cmp_clr),
        .en       (cmp_en),
        .off      (data_off),
        .exp_byte (buf_byte),
        .act_byte (xfer_rx),
        .mismatch (mismatch),
        .fail_off (fail_offset),
        .fail_exp (fail_expected),
        .fail_act (fail_actual)
    );

    always_comb begin
        unique case (ctl_q.ph)
            PH_WREN: last_idx = '0;
            PH_POLL: last_idx = POLL_LAST;
            default: last_idx = PAGE_LAST;
        endcase
    end

    always_comb begin
        ctl_d   = ctl_q;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        cmp_clr = 1'b0;
        cmp_en  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_CMD;
                    ctl_d.ph   = PH_WREN;
                    ctl_d.idx  = '0;
                    ctl_d.addr = page_addr;
                    ctl_d.tmo  = 1'b0;
                    tmr_clr    = 1'b1;
                    cmp_clr    = 1'b1;
                end
            end
            ST_CMD: begin
                if (xfer_ack) begin
                    if (ctl_q.ph == PH_READ && ctl_q.idx >= DATA_FIRST) begin
                        cmp_en = 1'b1;
                    end
                    if (ctl_q.idx == last_idx) begin
                        ctl_d.idx = '0;
                        unique case (ctl_q.ph)
                            PH_WREN: begin
                                ctl_d.st     = ST_GAP;
                                ctl_d.nxt_ph = PH_PROG;
                            end
                            PH_PROG: begin
                                ctl_d.st     = ST_GAP;
                                ctl_d.nxt_ph = PH_POLL;
                            end
                            PH_POLL: begin
                                if (xfer_rx[0]) begin
                                    tmr_inc = 1'b1;
                                    if (tmr_last) begin
                                        ctl_d.st  = ST_DONE;
                                        ctl_d.tmo = 1'b1;
                                    end else begin
                                        ctl_d.st     = ST_GAP;
                                        ctl_d.nxt_ph = PH_POLL;
                                    end
                                end else begin
                                    ctl_d.st     = ST_GAP;
                                    ctl_d.nxt_ph = PH_READ;
                                end
                            end
                            PH_READ: ctl_d.st = ST_DONE;
                            default: ctl_d.st = ST_DONE;
                        endcase
                    end else begin
                        ctl_d.idx = ctl_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_GAP: begin
                ctl_d.st = ST_CMD;
                ctl_d.ph = ctl_q.nxt_ph;
            end
            ST_DONE: ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, ph: PH_WREN, nxt_ph: PH_WREN,
                       idx: '0, addr: '0, tmo: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign xfer_req    = (ctl_q.st == ST_CMD);
    assign cs_n        = (ctl_q.st != ST_CMD);
    assign busy        = (ctl_q.st != ST_IDLE);
    assign done        = (ctl_q.st == ST_DONE);
    assign timeout_err = ctl_q.tmo;

endmodule

// File: rtl/spi_pv_chk.sv
module spi_pv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       cs_n,
    input logic       xfer_req,
    input logic [7:0] xfer_tx,
    input logic       xfer_ack,
    input logic       busy,
    input logic       done,
    input logic       mismatch,
    input logic       timeout_err
);

    assert_idle_cs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    assert_req_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !cs_n);

    assert_cs_rise_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(xfer_ack));

    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> !mismatch);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_only_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind spi_page_verify spi_pv_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cs_n        (cs_n),
    .xfer_req    (xfer_req),
    .xfer_tx     (xfer_tx),
    .xfer_ack    (xfer_ack),
    .busy        (busy),
    .done        (done),
    .mismatch    (mismatch),
    .timeout_err (timeout_err)
);

// File: tb/spi_page_verify_tb.sv
module spi_page_verify_tb;

    localparam int P     = 16;
    localparam int TO_W  = 8;
    localparam int OFF_W = $clog2(P);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [23:0]      page_addr = '0;
    logic [TO_W-1:0]  poll_limit = '0;
    logic             buf_wr_en = 1'b0;
    logic [OFF_W-1:0] buf_wr_addr = '0;
    logic [7:0]       buf_wr_data = '0;
    logic             cs_n, xfer_req, busy, done, mismatch, timeout_err;
    logic [7:0]       xfer_tx;
    logic             xfer_ack = 1'b0;
    logic [7:0]       xfer_rx = '0;
    logic [OFF_W-1:0] fail_offset;
    logic [7:0]       fail_expected, fail_actual;

    always #4 clk = ~clk;

    spi_page_verify #(.PAGE_BYTES(P), .TO_W(TO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_addr(page_addr),
        .poll_limit(poll_limit), .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr),
        .buf_wr_data(buf_wr_data), .cs_n(cs_n), .xfer_req(xfer_req),
        .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .busy(busy),
        .done(done), .mismatch(mismatch), .timeout_err(timeout_err),
        .fail_offset(fail_offset), .fail_expected(fail_expected),
        .fail_actual(fail_actual)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    int         len_q[$];
    logic [7:0] page [P];
    int busy_left = 0;
    int corr_a = -1;
    int corr_b = -1;
    localparam logic [7:0] MASK_A = 8'h5A;
    localparam logic [7:0] MASK_B = 8'h81;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    // Flash model and monitor: answers byte requests, pops the scoreboard.
    initial begin
        logic       prev_cs;
        int         fidx, wcnt, bytecnt, l, o;
        logic [7:0] op, first_tx, e, rx;
        string      tag;
        prev_cs = 1'b1; fidx = 0; wcnt = 0; bytecnt = 0; op = '0; first_tx = '0;
        forever begin
            @(negedge clk);
            xfer_ack = 1'b0;
            if (!rst_n) begin
                prev_cs = 1'b1;
                continue;
            end
            if (prev_cs && !cs_n) fidx = 0;
            if (!prev_cs && cs_n) begin
                if (len_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected frame", fidx, 0);
                end else begin
                    l = len_q.pop_front();
                    chk(fidx == l, "R6 frame length", fidx, l);
                end
            end
            prev_cs = cs_n;
            if (xfer_req) begin
                if (wcnt == 0) first_tx = xfer_tx;
                else chk(xfer_tx == first_tx, "R7 tx held", xfer_tx, first_tx);
                if (wcnt < (bytecnt % 3)) begin
                    wcnt++;
                end else begin
                    if (fidx == 0) op = xfer_tx;
                    case (op)
                        8'h06:   tag = "R2 write-enable byte";
                        8'h02:   tag = "R3 program byte";
                        8'h05:   tag = "R4 status byte";
                        8'h03:   tag = "R5 read byte";
                        default: tag = "R2 bad opcode";
                    endcase
                    if (exp_q.size() == 0) begin
                        chk(1'b0, {tag, " (none expected)"}, xfer_tx, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(xfer_tx == e, tag, xfer_tx, e);
                    end
                    rx = 8'hA5;
                    if (op == 8'h05 && fidx == 1) begin
                        if (busy_left > 0) begin
                            busy_left--;
                            rx = 8'h03;
                        end else begin
                            rx = 8'hFC;
                        end
                    end
                    if (op == 8'h03 && fidx >= 4) begin
                        o  = fidx - 4;
                        rx = page[o];
                        if (o == corr_a) rx = rx ^ MASK_A;
                        if (o == corr_b) rx = rx ^ MASK_B;
                    end
                    xfer_rx  = rx;
                    xfer_ack = 1'b1;
                    wcnt = 0;
                    fidx++;
                    bytecnt++;
                end
            end
        end
    end

    task automatic load_page(input logic [7:0] seed);
        for (int i = 0; i < P; i++) begin
            page[i] = seed + 8'(i * 37);
            @(negedge clk);
            buf_wr_en   = 1'b1;
            buf_wr_addr = OFF_W'(i);
            buf_wr_data = page[i];
        end
        @(negedge clk);
        buf_wr_en = 1'b0;
    endtask

    task automatic run_case(input logic [23:0] a, input int busy_n, input int lim,
                            input int ca, input int cb, input bit restart);
        int  lim_eff, polls, first, wd;
        bit  tmo, mm;
        logic [7:0] mask;
        lim_eff = (lim == 0) ? 1 : lim;
        tmo     = (busy_n >= lim_eff);
        polls   = tmo ? lim_eff : busy_n + 1;
        mm      = !tmo && (ca >= 0 || cb >= 0);
        first   = ca;
        mask    = MASK_A;
        if (ca < 0 || (cb >= 0 && cb < ca)) begin
            first = cb;
            mask  = MASK_B;
        end
        exp_q.push_back(8'h06); len_q.push_back(1);
        exp_q.push_back(8'h02);
        exp_q.push_back(a[23:16]); exp_q.push_back(a[15:8]); exp_q.push_back(a[7:0]);
        for (int i = 0; i < P; i++) exp_q.push_back(page[i]);
        len_q.push_back(P + 4);
        for (int k = 0; k < polls; k++) begin
            exp_q.push_back(8'h05); exp_q.push_back(8'h00); len_q.push_back(2);
        end
        if (!tmo) begin
            exp_q.push_back(8'h03);
            exp_q.push_back(a[23:16]); exp_q.push_back(a[15:8]); exp_q.push_back(a[7:0]);
            for (int i = 0; i < P; i++) exp_q.push_back(8'h00);
            len_q.push_back(P + 4);
        end
        busy_left = busy_n;
        corr_a    = ca;
        corr_b    = cb;
        @(negedge clk);
        page_addr  = a;
        poll_limit = TO_W'(lim);
        start      = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        page_addr = ~a;
        if (restart) begin
            repeat (30) @(negedge clk);
            chk(busy == 1'b1, "R12 busy mid-run", busy, 1);
            start     = 1'b1;
            page_addr = 24'h000777;
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        while (!done && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        chk(done == 1'b1, "R11 done reached", done, 1);
        chk(timeout_err == tmo, "R10 timeout flag", timeout_err, tmo);
        chk(mismatch == mm, "R8 R9 mismatch flag", mismatch, mm);
        if (mm) begin
            chk(fail_offset == OFF_W'(first), "R9 first offset", fail_offset, first);
            chk(fail_expected == page[first], "R9 expected byte", fail_expected, page[first]);
            chk(fail_actual == (page[first] ^ mask), "R9 actual byte", fail_actual,
                page[first] ^ mask);
        end
        @(negedge clk);
        chk(done == 1'b0, "R11 done one clock", done, 0);
        chk(busy == 1'b0, "R11 idle after done", busy, 0);
        repeat (10) @(negedge clk);
        chk(mismatch == mm && timeout_err == tmo, "R11 flags held",
            {mismatch, timeout_err}, {mm, tmo});
        chk(exp_q.size() == 0, "R3 R5 all bytes sent", exp_q.size(), 0);
        chk(len_q.size() == 0, "R6 all frames closed", len_q.size(), 0);
        chk(cs_n == 1'b1, "R12 no restarted run", cs_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && xfer_req == 1'b0, "R1 bus idle", {cs_n, xfer_req}, 2'b10);
        chk(busy == 1'b0 && done == 1'b0, "R1 no activity", {busy, done}, 0);
        chk(mismatch == 1'b0 && timeout_err == 1'b0, "R1 flags clear",
            {mismatch, timeout_err}, 0);
        rst_n = 1'b1;
        load_page(8'h11);
        run_case(24'hABCDEF, 0, 4, 5, 11, 1'b0);      // R9 two corruptions
        run_case(24'h123456, 2, 8, -1, -1, 1'b0);     // R8 R4 clears old flags
        run_case(24'h0F0F00, 10, 3, -1, -1, 1'b0);    // R10 limit reached
        run_case(24'h000100, 5, 0, -1, -1, 1'b0);     // R10 limit 0 acts as 1
        load_page(8'hC3);
        run_case(24'hFFFF00, 1, 6, P - 1, -1, 1'b1);  // R9 last offset, R12 restart
        run_case(24'h7E0000, 0, 1, 0, 3, 1'b0);       // R9 offset 0
        finish_run();
    end

endmodule